// File: doc/BRIEF.md
# Frame-Timed Constant-Rate Cell Scheduler

This block walks a programmable table of virtual-circuit identifiers and releases one of them for transmission each time a slow pacing strobe falls. The pacing strobe comes from outside and has no phase relation to the system clock. It is synchronised inside the block. The strobe also marks frames: when it stays high for a minimum number of system clocks, the table pointer returns to the first entry. The spacing between these returns therefore sets the frame length. A strobe that is high longer than that minimum on every period releases exactly one cell per period, which gives rate shaping from a slow strobe.

A downstream engine reports through a completion input that it has finished with the last released circuit. Until that report arrives, the block keeps at most one release waiting. Firmware loads the table through a simple write port and sets how many entries are live. After the last live entry the block goes quiet until the next frame start.

Top module: `cbr_frame_sched`

## Requirements
- R1: While reset is applied and after its release, `sched_valid` and `overrun` are 0 and the table pointer is at entry 0.
- R2: With no earlier release outstanding, a falling edge of `rate_strobe` gives a single-cycle `sched_valid`. It is visible after the third rising clock edge that follows the fall. It carries in `sched_vc` the entry at the pointer, and the pointer then advances by one.
- R3: While a released circuit has not been completed, a new request waits. It is released on the first clock edge at which `vc_done` is 1.
- R4: When the synchronised strobe is high for RWND_CLKS (8) consecutive clocks, the pointer returns to entry 0. A high time of RWND_CLKS-1 clocks leaves the pointer unchanged.
- R5: When the pointer equals `list_len`, falling edges release nothing and do not set `overrun` until a frame restart.
- R6: A falling edge that arrives while a request is already waiting is dropped. It sets `overrun`, which stays 1 until reset.
- R7: When a waiting request is released on the same edge as a frame restart, it carries the entry at the old pointer, and the next release carries entry 0.
- R8: A table write takes the single memory port. A release due in that cycle is deferred by one cycle and then reads the updated table.
- R9: `wr_data` written at `wr_addr` is returned as `sched_vc` when that entry is released. `list_len` ranges from 0 to 2^ADDR_W, and a value of 0 releases nothing.
- R10: `sched_valid` is never 1 on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_strobe | input | 1 | Asynchronous pacing and frame strobe |
| list_len | input | ADDR_W+1 | Number of live table entries |
| wr_en | input | 1 | Table write strobe |
| wr_addr | input | ADDR_W | Table write address |
| wr_data | input | VC_W | Circuit identifier to store |
| vc_done | input | 1 | Downstream completion of the last released circuit |
| sched_valid | output | 1 | One-cycle release pulse |
| sched_vc | output | VC_W | Released circuit identifier |
| overrun | output | 1 | Sticky dropped-request flag |

## Verification
Two actions can land on one clock edge: the release of a waiting request and the frame restart. The bench creates this by holding a request back with `vc_done` low and then raising the strobe. It asserts `vc_done` exactly in the cycle in which the eighth high sample restarts the frame. It checks that the pulse appears on that edge with the old entry and that the following fall returns entry 0. A second collision is a table write against a due read. This case is judged by the one-cycle delay and by whether the freshly written value is returned.

// File: rtl/cbrs_pkg.sv
package cbrs_pkg;

  // Events produced by the strobe front end, one clock wide each.
  typedef struct packed {
    logic fall;    // synchronised strobe went low
    logic rewind;  // strobe has been high long enough to restart the frame
  } cbrs_evt_t;

endpackage

// File: rtl/cbrs_rst_sync.sv
module cbrs_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] rst_q;
  logic [STAGES-1:0] rst_d;

  always_comb begin
    rst_d = {rst_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) rst_q <= '0;
    else         rst_q <= rst_d;
  end

  assign srst_n = rst_q[STAGES-1];

endmodule

// File: rtl/cbrs_strobe_det.sv
module cbrs_strobe_det
  import cbrs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned RWND_CLKS   = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      strobe_in,
  output cbrs_evt_t evt
);

  localparam int unsigned CNT_W = $clog2(RWND_CLKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(RWND_CLKS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RWND_CLKS - 1);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q;
  logic [CNT_W-1:0]       hi_cnt_q, hi_cnt_d;
  logic                   cnt_en;
  logic                   s_now;

  assign s_now = sync_q[SYNC_STAGES-1];

  // next state
  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], strobe_in};
    cnt_en = !s_now || (hi_cnt_q != CNT_MAX);
    if (!s_now) hi_cnt_d = '0;
    else        hi_cnt_d = hi_cnt_q + CNT_W'(1);
    evt.fall   = prev_q && !s_now;
    evt.rewind = s_now && (hi_cnt_q == CNT_LAST);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= '0;
      prev_q   <= 1'b0;
      hi_cnt_q <= '0;
    end else begin
      sync_q <= sync_d;
      prev_q <= s_now;
      if (cnt_en) hi_cnt_q <= hi_cnt_d;
    end
  end

  // saturating counter never passes its ceiling
  p_cnt_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hi_cnt_q <= CNT_MAX);

  // one restart per high period
  p_rewind_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt.rewind |=> !evt.rewind);

  // a restart needs the strobe high on the previous cycle too
  p_rewind_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt.rewind |-> $past(s_now));

endmodule

// File: rtl/cbrs_list_ram.sv
module cbrs_list_ram #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end

endmodule

// File: rtl/cbrs_sched_ctrl.sv
module cbrs_sched_ctrl
  import cbrs_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cbrs_evt_t         evt,
  input  logic [ADDR_W:0]   list_len,
  input  logic              wr_busy,
  input  logic              vc_done,
  output logic              issue,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              sched_valid,
  output logic              overrun
);

  localparam logic [ADDR_W:0] DEPTH = (ADDR_W+1)'(1) << ADDR_W;
  localparam logic [ADDR_W:0] ONE   = (ADDR_W+1)'(1);

  logic [ADDR_W:0] ptr_q, ptr_d;
  logic            ptr_en;
  logic            pend_q, pend_d;
  logic            busy_q, busy_d;
  logic            vld_q;
  logic            ovr_q, ovr_d;
  logic            req, at_end, may_go;

  // next state
  always_comb begin
    req    = evt.fall || pend_q;
    at_end = (ptr_q >= list_len);
    may_go = !busy_q || vc_done;
    issue  = req && !at_end && may_go && !wr_busy;

    ptr_en = evt.rewind || issue;
    if (evt.rewind) ptr_d = '0;
    else            ptr_d = ptr_q + ONE;

    pend_d = req && !issue && !at_end;
    ovr_d  = ovr_q || (evt.fall && pend_q);

    if (issue)        busy_d = 1'b1;
    else if (vc_done) busy_d = 1'b0;
    else              busy_d = busy_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      vld_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (ptr_en) ptr_q <= ptr_d;
      pend_q <= pend_d;
      busy_q <= busy_d;
      vld_q  <= issue;
      ovr_q  <= ovr_d;
    end
  end

  assign rd_addr     = ptr_q[ADDR_W-1:0];
  assign sched_valid = vld_q;
  assign overrun     = ovr_q;

  p_no_back2back_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sched_valid |=> !sched_valid);

  p_rewind_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    evt.rewind |=> (ptr_q == '0));

  p_hold_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !vc_done) |=> !sched_valid);

  p_sticky_ovr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |=> !sched_valid);

  p_end_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && !evt.rewind && $stable(list_len)) |=> (!sched_valid && $stable(ptr_q)));

  p_ptr_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= DEPTH);

endmodule

// File: rtl/cbr_frame_sched.sv
module cbr_frame_sched
  import cbrs_pkg::*;
#(
  parameter int unsigned ADDR_W      = 10,
  parameter int unsigned VC_W        = 16,
  parameter int unsigned RWND_CLKS   = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rate_strobe,
  input  logic [ADDR_W:0]   list_len,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [VC_W-1:0]   wr_data,
  input  logic              vc_done,
  output logic              sched_valid,
  output logic [VC_W-1:0]   sched_vc,
  output logic              overrun
);

  logic              srst_n;
  cbrs_evt_t         evt;
  logic              issue;
  logic [ADDR_W-1:0] rd_addr;
  logic [ADDR_W-1:0] ram_addr;
  logic              ram_en;

  cbrs_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  cbrs_strobe_det #(
    .SYNC_STAGES (SYNC_STAGES),
    .RWND_CLKS   (RWND_CLKS)
  ) u_strobe (
    .clk       (clk),
    .rst_n     (srst_n),
    .strobe_in (rate_strobe),
    .evt       (evt)
  );

  cbrs_sched_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (srst_n),
    .evt         (evt),
    .list_len    (list_len),
    .wr_busy     (wr_en),
    .vc_done     (vc_done),
    .issue       (issue),
    .rd_addr     (rd_addr),
    .sched_valid (sched_valid),
    .overrun     (overrun)
  );

  // single port: the write owns the address when both want it
  always_comb begin
    ram_en   = wr_en || issue;
    ram_addr = wr_en ? wr_addr : rd_addr;
  end

  cbrs_list_ram #(.ADDR_W(ADDR_W), .DATA_W(VC_W)) u_ram (
    .clk   (clk),
    .en    (ram_en),
    .we    (wr_en),
    .addr  (ram_addr),
    .wdata (wr_data),
    .rdata (sched_vc)
  );

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(srst_n) |-> (!sched_valid && !overrun));

endmodule

// File: tb/cbr_frame_sched_bench.sv
module cbr_frame_sched_bench;

  localparam int AW = 3;
  localparam int VW = 16;

  logic          clk;
  logic          rst_n;
  logic          rate_strobe;
  logic [AW:0]   list_len;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [VW-1:0] wr_data;
  logic          vc_done;
  logic          sched_valid;
  logic [VW-1:0] sched_vc;
  logic          overrun;

  int n_tests = 0;
  int n_fail  = 0;
  int nv      = 0;
  int b2b     = 0;
  bit prev_v  = 0;
  logic [VW-1:0] vlog [0:511];

  cbr_frame_sched #(.ADDR_W(AW), .VC_W(VW)) u_cbr_frame_sched (
    .clk(clk), .rst_n(rst_n), .rate_strobe(rate_strobe), .list_len(list_len),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .vc_done(vc_done),
    .sched_valid(sched_valid), .sched_vc(sched_vc), .overrun(overrun)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [VW-1:0] ent(input int i);
    return VW'(16'hC0DE + i * 977);
  endfunction

  always @(negedge clk) begin
    if (sched_valid) begin
      if (nv < 512) vlog[nv] = sched_vc;
      nv++;
      if (prev_v) b2b++;
    end
    prev_v = sched_valid;
  end

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(input int hi, input int lo);
    rate_strobe = 1'b1;
    repeat (hi) tick();
    rate_strobe = 1'b0;
    repeat (lo) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int v0;
    rst_n = 1'b0; rate_strobe = 1'b0; list_len = 4'd8;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; vc_done = 1'b1;
    repeat (3) tick();
    chk(!sched_valid && !overrun, "R1 in reset", {sched_valid, overrun}, 0);
    rst_n = 1'b1;
    repeat (4) tick();
    chk(!sched_valid && !overrun, "R1 after release", {sched_valid, overrun}, 0);

    // load table (R9)
    for (int i = 0; i < 8; i++) begin
      wr_en = 1'b1; wr_addr = AW'(i); wr_data = ent(i);
      tick();
    end
    wr_en = 1'b0;
    repeat (3) tick();
    chk(nv == 0, "R9 writes release nothing", nv, 0);

    // R2 latency of the first release
    rate_strobe = 1'b1; repeat (4) tick();
    rate_strobe = 1'b0; v0 = nv;
    tick(); chk(!sched_valid, "R2 edge1 quiet", sched_valid, 0);
    tick(); chk(!sched_valid, "R2 edge2 quiet", sched_valid, 0);
    tick(); chk(sched_valid && sched_vc == ent(0), "R2 edge3 entry0", sched_vc, ent(0));
    repeat (3) tick();

    // R2 walk through the remaining entries
    for (int i = 1; i < 8; i++) begin
      v0 = nv;
      pulse(3, 6);
      chk(nv == v0 + 1 && vlog[v0] == ent(i), "R2 sweep entry", vlog[v0], ent(i));
    end

    // R5 end of list
    v0 = nv;
    pulse(3, 6); pulse(3, 6);
    chk(nv == v0, "R5 no release at end", nv - v0, 0);
    chk(!overrun, "R5 no overrun at end", overrun, 0);

    // R4 boundary: 7 clocks high does not restart, 8 does
    v0 = nv;
    pulse(7, 6);
    chk(nv == v0, "R4 seven high no restart", nv - v0, 0);
    pulse(8, 6);
    chk(nv == v0 + 1 && vlog[v0] == ent(0), "R4 eight high restart", vlog[v0], ent(0));

    // R5/R9 sweep over every list length
    for (int len = 0; len <= 8; len++) begin
      list_len = 4'(len);
      v0 = nv;
      pulse(12, 6);
      for (int j = 0; j <= len; j++) pulse(3, 6);
      chk(nv == v0 + len, "R5 count for length", nv - v0, len);
      for (int j = 0; j < len; j++)
        chk(vlog[v0 + j] == ent(j), "R9 entry value", vlog[v0 + j], ent(j));
    end
    list_len = 4'd8;

    // R3 hold until done
    vc_done = 1'b0;
    repeat (2) tick();
    v0 = nv;
    pulse(12, 6);
    chk(nv == v0 + 1 && vlog[v0] == ent(0), "R3 first release", vlog[v0], ent(0));
    v0 = nv;
    pulse(3, 6);
    repeat (20) tick();
    chk(nv == v0, "R3 waits for done", nv - v0, 0);
    vc_done = 1'b1;
    tick();
    chk(sched_valid && sched_vc == ent(1), "R3 release on done", sched_vc, ent(1));
    vc_done = 1'b0;

    // R6 overrun
    v0 = nv;
    pulse(3, 6);
    pulse(3, 6);
    chk(overrun, "R6 overrun set", overrun, 1);
    chk(nv == v0, "R6 nothing while busy", nv - v0, 0);
    vc_done = 1'b1; tick(); vc_done = 1'b0;
    repeat (10) tick();
    chk(nv == v0 + 1 && vlog[v0] == ent(2), "R6 single release", nv - v0, 1);
    chk(overrun, "R6 overrun sticky", overrun, 1);

    // R7 release and restart on the same edge
    pulse(3, 6);
    v0 = nv;
    rate_strobe = 1'b1;
    repeat (9) tick();
    vc_done = 1'b1;
    tick();
    chk(sched_valid && sched_vc == ent(3), "R7 old entry on restart edge", sched_vc, ent(3));
    repeat (2) tick();
    rate_strobe = 1'b0;
    repeat (6) tick();
    chk(nv == v0 + 2 && vlog[v0 + 1] == ent(0), "R7 next is entry0", vlog[v0 + 1], ent(0));

    // R8 write collides with a due read (pointer is now 1)
    rate_strobe = 1'b1; repeat (4) tick();
    rate_strobe = 1'b0;
    tick(); tick();
    wr_en = 1'b1; wr_addr = AW'(1); wr_data = 16'h5A5A;
    tick();
    chk(!sched_valid, "R8 deferred by write", sched_valid, 0);
    wr_en = 1'b0;
    tick();
    chk(sched_valid && sched_vc == 16'h5A5A, "R8 reads new value", sched_vc, 16'h5A5A);
    repeat (4) tick();

    chk(b2b == 0, "R10 no back-to-back pulses", b2b, 0);

    // R1 again: reset clears sticky flag
    rst_n = 1'b0;
    tick();
    chk(!sched_valid && !overrun, "R1 reset clears", {sched_valid, overrun}, 0);
    rst_n = 1'b1;
    repeat (4) tick();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule